// File: doc/BRIEF.md
# Bit-serial fixed-coefficient multiplier

The block multiplies a serial operand by an N-bit multiplicand presented in parallel on `coef`. Operand bits enter one at a time, least significant first, and for every accepted operand bit exactly one product bit leaves, also least significant first. After k operand bits the output stream holds the product reduced modulo 2^k. To get the full product, the operand is followed by N zero bits. Because the stream keeps running, several operands can be sent back to back. Each one is padded with N zeros, and the output is then the products laid end to end.

Internally there is a chain of N identical cells. Each cell holds one multiplicand bit and one carry. The operand, its valid flag and its start flag move down the chain by one register per cell. The partial-sum bits move back up the chain by one register per cell. Neighbouring cells are clocked on opposite edges, so each hop costs half a cycle in each direction. This lets the product bit leave on the same falling edge that accepts the operand bit, whatever the value of N. A low `in_valid` stalls the chain. A start flag sent with the first bit of a new operand clears all carries and all partial sums that were in flight.

Top module: `serial_coef_mult`

## Requirements
- R1: `prod_valid` is high for exactly one cycle after each falling edge at which `in_valid` was high, and low after each falling edge at which it was low. One product bit is produced per operand bit.
- R2: With operand bits applied least significant first and the first bit flagged with `in_start`, product bit j equals bit j of `coef` × operand. After k bits the stream therefore equals (`coef` × operand) mod 2^k.
- R3: A bit applied with `in_valid` and `in_start` both high discards every stored carry and pending partial sum. The product bit it produces equals `coef[0]` AND `in_bit`, whatever came before.
- R4: While `in_valid` is low, no cell advances. `prod_bit` keeps its value and `in_start`/`in_bit` are ignored. Any number of stall cycles between operand bits leaves the product unchanged.
- R5: With only the top multiplicand bit set (`coef` = 2^(N-1)), the product is the operand shifted up by N-1. This shows that the stage past the last cell returns zero partial sums.
- R6: Operands each followed by N zero bits, sent after a single start, give output chunks that each equal the product of the matching operand.
- R7: The product bit for an operand bit accepted at a falling edge is driven on `prod_bit` from that same falling edge. The latency does not depend on N.
- R8: While `rst_n` is low across clock edges, `prod_valid` and `prod_bit` are 0. The first operand after reset gives the correct product without `in_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Even cells and the output use the falling edge, odd cells the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| coef | input | N | Multiplicand. Must be held constant for the whole of an operand |
| in_valid | input | 1 | Operand bit qualifier. Low stalls the chain |
| in_start | input | 1 | Marks the first bit of a new operand |
| in_bit | input | 1 | Serial operand bit, least significant first |
| prod_valid | output | 1 | High when `prod_bit` carries a new product bit |
| prod_bit | output | 1 | Serial product bit, least significant first |

## Verification
The bench sweeps every 4-bit multiplicand against every 4-bit operand, padded to full width, with stalls inserted at random on half of the sweep. A wrong return-path timing, or a wrong forward-path timing, shifts partial sums by one bit position and corrupts almost every product. A stall that leaks into any cell shows up as a held output that moves, or as a wrong product after the pause. A restart is fired after unpadded operands that leave live carries behind. A design that clears the carries but not the pending partial sums, or clears neither, gives a wrong low bit. The top-coefficient case and the back-to-back padded stream catch a last stage that returns anything other than zero, and any carry that leaks across operand boundaries.

// File: rtl/serial_coef_mult.sv
module serial_coef_mult #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] coef,
  input  logic         in_valid,
  input  logic         in_start,
  input  logic         in_bit,
  output logic         prod_valid,
  output logic         prod_bit
);

  logic [N-1:0] op_in, vld_in, clr_in, ps_in, ps_q;

  assign op_in[0]  = in_bit;
  assign vld_in[0] = in_valid;
  assign clr_in[0] = in_start & in_valid;

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic cclk, pp, bb, cc, s, cy, carry_q, ps_r;

    assign cclk = (i % 2 == 0) ? ~clk : clk;
    assign pp   = coef[i] & op_in[i];
    assign bb   = ps_in[i] & ~clr_in[i];
    assign cc   = carry_q & ~clr_in[i];
    assign s    = pp ^ bb ^ cc;
    assign cy   = (pp & bb) | (pp & cc) | (bb & cc);

    always_ff @(posedge cclk) begin
      if (!rst_n) begin
        ps_r    <= 1'b0;
        carry_q <= 1'b0;
      end else if (vld_in[i]) begin
        ps_r    <= s;
        carry_q <= cy;
      end
    end
    assign ps_q[i] = ps_r;

    if (i == N - 1) begin : g_end
      assign ps_in[i] = 1'b0;
    end else begin : g_fwd
      logic op_r, vld_r, clr_r;
      always_ff @(posedge cclk) begin
        if (!rst_n) begin
          op_r  <= 1'b0;
          vld_r <= 1'b0;
          clr_r <= 1'b0;
        end else begin
          op_r  <= op_in[i];
          vld_r <= vld_in[i];
          clr_r <= clr_in[i];
        end
      end
      assign op_in[i+1]  = op_r;
      assign vld_in[i+1] = vld_r;
      assign clr_in[i+1] = clr_r;
      assign ps_in[i]    = ps_q[i+1];
    end
  end

  always_ff @(negedge clk) begin
    if (!rst_n) prod_valid <= 1'b0;
    else        prod_valid <= in_valid;
  end

  assign prod_bit = ps_q[0];

  // R1
  valid_follow_chk: assert property (@(negedge clk) disable iff (!rst_n)
    in_valid |=> prod_valid);

  // R1
  no_spurious_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !in_valid |=> !prod_valid);

  // R3
  restart_low_bit_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (in_valid && in_start) |=> (prod_bit == ($past(coef[0]) & $past(in_bit))));

  // R4
  stall_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(prod_bit));

endmodule

// File: tb/sim_serial_coef_mult.sv
module sim_serial_coef_mult;
  localparam int CLK_T = 10;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] coef = '0;
  logic in_valid = 1'b0, in_start = 1'b0, in_bit = 1'b0;
  logic prod_valid, prod_bit;

  int errs = 0;
  int checks = 0;
  logic last_bit = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  logic stall_on = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  serial_coef_mult #(.N(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .coef(coef), .in_valid(in_valid),
    .in_start(in_start), .in_bit(in_bit),
    .prod_valid(prod_valid), .prod_bit(prod_bit)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  endtask

  task automatic idle();
    @(posedge clk);
    #(CLK_T/4);
    in_valid = 1'b0;
    in_start = lfsr[2];
    in_bit   = lfsr[3];
    step_lfsr();
    #(CLK_T/2);
    check(prod_valid == 1'b0, "R1 valid low in stall", prod_valid, 0);
    check(prod_bit == last_bit, "R4 output held in stall", prod_bit, last_bit);
  endtask

  task automatic push(input logic b, input logic s, output logic got);
    if (stall_on && lfsr[1:0] == 2'b00) idle();
    step_lfsr();
    @(posedge clk);
    #(CLK_T/4);
    in_valid = 1'b1;
    in_start = s;
    in_bit   = b;
    #(CLK_T/2);
    check(prod_valid == 1'b1, "R7 product bit in same cycle", prod_valid, 1);
    got = prod_bit;
    last_bit = prod_bit;
  endtask

  task automatic run_op(input int k, input longint a, input logic s, output longint res);
    res = 0;
    for (int j = 0; j < k; j++) begin
      logic g;
      push(a[j], s && (j == 0), g);
      res = res | (longint'(g) << j);
    end
  endtask

  initial begin
    longint r, r1, r2, r3, exp;
    repeat (3) @(posedge clk);
    #(3*CLK_T/4);
    check(prod_valid == 1'b0, "R8 reset valid", prod_valid, 0);
    check(prod_bit == 1'b0, "R8 reset bit", prod_bit, 0);
    @(posedge clk);
    #(CLK_T/4);
    rst_n = 1'b1;

    coef = 4'd6;
    run_op(8, 5, 1'b0, r);
    check(r == 30, "R8 first operand without start", r, 30);

    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 16; a++) begin
        coef = c[NB-1:0];
        stall_on = c[0];
        run_op(8, a, 1'b1, r);
        exp = (c * a) & 255;
        if (c == 8)        check(r == exp, "R5 top multiplicand bit", r, exp);
        else if (stall_on) check(r == exp, "R4 stalled sweep", r, exp);
        else               check(r == exp, "R2 sweep", r, exp);
      end
    end
    stall_on = 1'b1;

    coef = 4'd13;
    run_op(8, 15, 1'b1, r1);
    run_op(8, 7, 1'b0, r2);
    run_op(8, 11, 1'b0, r3);
    check(r1 == 195, "R6 chunk 1", r1, 195);
    check(r2 == 91, "R6 chunk 2", r2, 91);
    check(r3 == 143, "R6 chunk 3", r3, 143);

    coef = 4'd11;
    run_op(6, 45, 1'b1, r);
    exp = (11 * 45) % 64;
    check(r == exp, "R2 truncated to 6 bits", r, exp);

    coef = 4'd15;
    run_op(5, 31, 1'b1, r);
    run_op(8, 9, 1'b1, r);
    check(r[0] == 1'b1, "R3 low bit after restart", r[0], 1);
    check(r == 135, "R3 product after restart", r, 135);

    coef = 4'd14;
    run_op(5, 31, 1'b1, r);
    run_op(8, 3, 1'b1, r);
    check(r[0] == 1'b0, "R3 low bit after restart", r[0], 0);
    check(r == 42, "R3 product after restart", r, 42);

    idle();
    idle();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_T * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule